// File: doc/BRIEF.md
# Aliased Architectural Register File

This block holds the architectural register state of a small processor core: four 64-bit general registers, a stack pointer, an instruction pointer, an 8-bit flags register and a 16-bit control register. The general registers and the stack pointer sit behind one write port and two combinational read ports. Each port carries a size selector, so an operand can be handled as a full word or as a narrower view of 32, 16 or 8 bits. A narrow view is the least-significant slice of its parent register.

Execution results reach the flags through a dedicated update input. The exception logic sets and clears the control-register status bits through set and clear masks. The instruction pointer moves only by a load (for a branch) or by a step (for the length of the current instruction). Software cannot write the instruction pointer or the control register through the write port. Push and pop adjust the stack pointer by the operand size.

Reset is synchronous and active-low. It clears a fixed subset of the state and loads the hardware version into the control register.

Top module: `arch_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, the general registers, the stack pointer and the flags become zero, the instruction pointer becomes `BOOT_IP`, and `cr_out` becomes `{VER_MAJOR, VER_MINOR, 8'h00}`.
- R2: A write with size 3 (word) replaces all 64 bits of the selected register. The value can be read back from the next cycle on. Reads are combinational and return the state as it stood before the edge.
- R3: Write size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. A write of size 0, 1 or 2 replaces only bits [7:0], [15:0] or [31:0] of the target. The other bits of the target keep their value.
- R4: A read of size 0, 1 or 2 returns bits [7:0], [15:0] or [31:0] of the selected register, zero-extended to 64 bits.
- R5: Selector values 0 to 3 address r0 to r3, and selector 4 addresses the stack pointer. A selector above 4 reads as zero, and a write to it changes no register.
- R6: The flags are bit 7 zero, bit 6 greater-than, bit 5 remainder and bit 4 parity. `flags_we` loads bits [7:4] from `flags_in`. Bits [3:0] always read as zero. Without `flags_we` the flags hold their value.
- R7: `sp_adj_en` moves the stack pointer by 1, 2, 4 or 8 for size codes 0 to 3. It decrements when `sp_adj_pop` is 0 (push) and increments when it is 1 (pop), with modulo-2^64 wrap. A write-port write to selector 4 in the same cycle takes precedence over the adjustment.
- R8: `ip_load_en` loads the instruction pointer from `ip_load_val`. Otherwise `ip_step_en` adds `ip_step`. The load takes precedence when both are asserted.
- R9: In the control register, bit 7 (in-exception) and bit 6 (table-modified) are set by `cr_set` and cleared by `cr_clr`, and set wins when both are asserted for the same bit. Bits [5:0] ignore both masks and read as zero. Bits [15:8] always show the version.
- R10: The two read ports select registers and sizes independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_sel | input | 3 | Read port A register selector |
| rd_a_size | input | 2 | Read port A view size |
| rd_a_data | output | 64 | Read port A zero-extended data |
| rd_b_sel | input | 3 | Read port B register selector |
| rd_b_size | input | 2 | Read port B view size |
| rd_b_data | output | 64 | Read port B zero-extended data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Write register selector |
| wr_size | input | 2 | Write view size |
| wr_data | input | 64 | Write data (low bits used for narrow sizes) |
| sp_adj_en | input | 1 | Stack pointer adjust enable |
| sp_adj_pop | input | 1 | 1 = pop (increment), 0 = push (decrement) |
| sp_adj_size | input | 2 | Operand size of the push or pop |
| sp_out | output | 64 | Stack pointer value |
| ip_load_en | input | 1 | Instruction pointer load enable |
| ip_load_val | input | 64 | Instruction pointer load value |
| ip_step_en | input | 1 | Instruction pointer step enable |
| ip_step | input | 4 | Instruction length to add |
| ip_out | output | 64 | Instruction pointer value |
| flags_we | input | 1 | Flags update enable |
| flags_in | input | 8 | New flags from execution |
| flags_out | output | 8 | Flags value |
| cr_set | input | 8 | Control register low-byte set mask |
| cr_clr | input | 8 | Control register low-byte clear mask |
| cr_out | output | 16 | Control register value |

## Verification
The bench builds the block with the default four general registers of 64 bits and overrides the version to major 0xA and minor 0x5. Distinct version nibbles make any swap of the version fields visible. Because the selector is only 3 bits wide, the write and read sweeps can cover every selector, including the three unused codes, against every size on both ports. With an 8-bit flags input and small control masks, every flags value and every set/clear pairing over the live and reserved bits can be driven exhaustively.

// File: rtl/regfile_pkg.sv
// Shared constants for the architectural register file: size codes and
// bit positions of the flags and control-register fields.
package regfile_pkg;
    // Operand size codes used on every port that carries a size selector.
    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_SHORT = 2'd1;
    localparam logic [1:0] SZ_HALF  = 2'd2;
    localparam logic [1:0] SZ_WORD  = 2'd3;

    // Flags bit positions.
    localparam int FL_ZERO    = 7;
    localparam int FL_GREATER = 6;
    localparam int FL_REMAIN  = 5;
    localparam int FL_PARITY  = 4;
    localparam logic [7:0] FLAGS_LIVE = (8'd1 << FL_ZERO) | (8'd1 << FL_GREATER)
                                      | (8'd1 << FL_REMAIN) | (8'd1 << FL_PARITY);

    // Control-register low-byte status bits.
    localparam int CR_IN_EXC   = 7;
    localparam int CR_TBL_MOD  = 6;
    localparam logic [7:0] CR_LIVE = (8'd1 << CR_IN_EXC) | (8'd1 << CR_TBL_MOD);
endpackage

// File: rtl/rf_size_view.sv
// Narrow-view extractor: returns the least-significant 8/16/32 bits of a
// word, zero-extended, or the whole word. Assumes W >= 64 slices make sense;
// with an all-ones input it yields the byte-lane mask for a write.
module rf_size_view #(
    parameter int W = 64
) (
    input  logic [W-1:0] word_i,
    input  logic [1:0]   size_i,
    output logic [W-1:0] view_o
);
    import regfile_pkg::*;

    localparam int B_W = (W < 8)  ? W : 8;
    localparam int S_W = (W < 16) ? W : 16;
    localparam int H_W = (W < 32) ? W : 32;

    // Select the slice for the requested size.
    always_comb begin
        unique case (size_i)
            SZ_BYTE:  view_o = W'(word_i[B_W-1:0]);
            SZ_SHORT: view_o = W'(word_i[S_W-1:0]);
            SZ_HALF:  view_o = W'(word_i[H_W-1:0]);
            default:  view_o = word_i;
        endcase
    end
endmodule

// File: rtl/rf_reg_bank.sv
// Bank of data registers: NREG-1 general registers plus the stack pointer
// at the highest index. One sized write port with lane merge, two
// combinational read ports (out-of-range selectors read zero), and a
// push/pop adjuster on the stack pointer that yields to an explicit write.
module rf_reg_bank #(
    parameter int W     = 64,
    parameter int NREG  = 5,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [1:0]       wr_size,
    input  logic [W-1:0]     wr_data,
    input  logic             sp_adj_en,
    input  logic             sp_adj_pop,
    input  logic [1:0]       sp_adj_size,
    input  logic [SEL_W-1:0] rd_a_sel,
    input  logic [SEL_W-1:0] rd_b_sel,
    output logic [W-1:0]     rd_a_word,
    output logic [W-1:0]     rd_b_word,
    output logic [W-1:0]     sp_word
);
    localparam int SP_IDX = NREG - 1;

    logic [NREG-1:0][W-1:0] regs;
    logic [W-1:0]           wr_mask;
    logic [W-1:0]           sp_step;

    // Lane mask of the write: the view of an all-ones word.
    rf_size_view #(.W(W)) u_wmask (
        .word_i ({W{1'b1}}),
        .size_i (wr_size),
        .view_o (wr_mask)
    );

    // Byte count of a push or pop: 1, 2, 4 or 8.
    assign sp_step = W'(1) << sp_adj_size;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_ent
            logic [W-1:0] q;
            logic         hit;
            assign hit = wr_en && (int'(wr_sel) == i);

            if (i == SP_IDX) begin : g_sp
                // Stack pointer: explicit write, else push/pop adjustment.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q <= '0;
                    else if (hit)
                        q <= (q & ~wr_mask) | (wr_data & wr_mask);
                    else if (sp_adj_en)
                        q <= sp_adj_pop ? (q + sp_step) : (q - sp_step);
                end
            end else begin : g_gpr
                // General register: merge the written lanes only.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q <= '0;
                    else if (hit)
                        q <= (q & ~wr_mask) | (wr_data & wr_mask);
                end
            end

            assign regs[i] = q;
        end
    endgenerate

    // Read port A: selected register or zero when out of range.
    always_comb begin
        rd_a_word = '0;
        for (int j = 0; j < NREG; j++)
            if (int'(rd_a_sel) == j) rd_a_word = regs[j];
    end

    // Read port B: selected register or zero when out of range.
    always_comb begin
        rd_b_word = '0;
        for (int j = 0; j < NREG; j++)
            if (int'(rd_b_sel) == j) rd_b_word = regs[j];
    end

    assign sp_word = regs[SP_IDX];
endmodule

// File: rtl/rf_ip_unit.sv
// Instruction pointer: loaded for a branch, or advanced by the length of
// the instruction just consumed. A load overrides a step in the same cycle.
module rf_ip_unit #(
    parameter int             W      = 64,
    parameter int             STEP_W = 4,
    parameter logic [W-1:0]   BOOT   = W'('h800)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [W-1:0]      load_val,
    input  logic              step_en,
    input  logic [STEP_W-1:0] step_len,
    output logic [W-1:0]      ip_o
);
    logic [W-1:0] ip_q;

    // Reset to boot address, then load or step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ip_q <= BOOT;
        else if (load_en)
            ip_q <= load_val;
        else if (step_en)
            ip_q <= ip_q + W'(step_len);
    end

    assign ip_o = ip_q;
endmodule

// File: rtl/rf_status.sv
// Flags and control register. Flags load from execution results with the
// reserved low nibble forced to zero. The control register low byte holds
// two status bits driven by set/clear masks (set wins); the upper byte is
// the fixed hardware version.
module rf_status #(
    parameter logic [3:0] VER_MAJOR = 4'h1,
    parameter logic [3:0] VER_MINOR = 4'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flags_we,
    input  logic [7:0]  flags_in,
    input  logic [7:0]  cr_set,
    input  logic [7:0]  cr_clr,
    output logic [7:0]  flags_o,
    output logic [15:0] cr_o
);
    import regfile_pkg::*;

    logic [7:0] flags_q;
    logic [7:0] cr_lo_q;

    // Flags: load live bits on update, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (flags_we)
            flags_q <= flags_in & FLAGS_LIVE;
    end

    // Control status bits: clear then set, reserved positions never move.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cr_lo_q <= '0;
        else
            cr_lo_q <= ((cr_lo_q & ~(cr_clr & CR_LIVE)) | (cr_set & CR_LIVE));
    end

    assign flags_o = flags_q;
    assign cr_o    = {VER_MAJOR, VER_MINOR, cr_lo_q};
endmodule

// File: rtl/arch_regfile.sv
// Architectural register file top: general registers and stack pointer
// behind sized read/write ports, instruction pointer, flags and control
// register. Selector NGPR addresses the stack pointer; higher codes are
// unused. Synchronous active-low reset.
module arch_regfile #(
    parameter int                  DATA_W    = 64,
    parameter int                  NGPR      = 4,
    parameter int                  IP_STEP_W = 4,
    parameter logic [DATA_W-1:0]   BOOT_IP   = DATA_W'('h800),
    parameter logic [3:0]          VER_MAJOR = 4'h1,
    parameter logic [3:0]          VER_MINOR = 4'h1,
    localparam int                 NREG      = NGPR + 1,
    localparam int                 SEL_W     = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     rd_a_sel,
    input  logic [1:0]           rd_a_size,
    output logic [DATA_W-1:0]    rd_a_data,
    input  logic [SEL_W-1:0]     rd_b_sel,
    input  logic [1:0]           rd_b_size,
    output logic [DATA_W-1:0]    rd_b_data,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [1:0]           wr_size,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 sp_adj_en,
    input  logic                 sp_adj_pop,
    input  logic [1:0]           sp_adj_size,
    output logic [DATA_W-1:0]    sp_out,
    input  logic                 ip_load_en,
    input  logic [DATA_W-1:0]    ip_load_val,
    input  logic                 ip_step_en,
    input  logic [IP_STEP_W-1:0] ip_step,
    output logic [DATA_W-1:0]    ip_out,
    input  logic                 flags_we,
    input  logic [7:0]           flags_in,
    output logic [7:0]           flags_out,
    input  logic [7:0]           cr_set,
    input  logic [7:0]           cr_clr,
    output logic [15:0]          cr_out
);
    logic [DATA_W-1:0] word_a;
    logic [DATA_W-1:0] word_b;

    rf_reg_bank #(.W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_size     (wr_size),
        .wr_data     (wr_data),
        .sp_adj_en   (sp_adj_en),
        .sp_adj_pop  (sp_adj_pop),
        .sp_adj_size (sp_adj_size),
        .rd_a_sel    (rd_a_sel),
        .rd_b_sel    (rd_b_sel),
        .rd_a_word   (word_a),
        .rd_b_word   (word_b),
        .sp_word     (sp_out)
    );

    rf_size_view #(.W(DATA_W)) u_view_a (
        .word_i (word_a),
        .size_i (rd_a_size),
        .view_o (rd_a_data)
    );

    rf_size_view #(.W(DATA_W)) u_view_b (
        .word_i (word_b),
        .size_i (rd_b_size),
        .view_o (rd_b_data)
    );

    rf_ip_unit #(.W(DATA_W), .STEP_W(IP_STEP_W), .BOOT(BOOT_IP)) u_ip (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (ip_load_en),
        .load_val (ip_load_val),
        .step_en  (ip_step_en),
        .step_len (ip_step),
        .ip_o     (ip_out)
    );

    rf_status #(.VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_we (flags_we),
        .flags_in (flags_in),
        .cr_set   (cr_set),
        .cr_clr   (cr_clr),
        .flags_o  (flags_out),
        .cr_o     (cr_out)
    );
endmodule

// File: rtl/rf_checker.sv
// Property checker for arch_regfile, attached through bind. Observes ports
// only; every property is disabled while reset is asserted.
module rf_checker #(
    parameter int                DATA_W  = 64,
    parameter int                NGPR    = 4,
    parameter int                SEL_W   = 3,
    parameter logic [DATA_W-1:0] BOOT_IP = DATA_W'('h800)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [SEL_W-1:0]  rd_a_sel,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              sp_adj_en,
    input logic              sp_adj_pop,
    input logic [1:0]        sp_adj_size,
    input logic [DATA_W-1:0] sp_out,
    input logic              ip_load_en,
    input logic [DATA_W-1:0] ip_load_val,
    input logic [DATA_W-1:0] ip_out,
    input logic              flags_we,
    input logic [7:0]        flags_in,
    input logic [7:0]        flags_out,
    input logic [7:0]        cr_set,
    input logic [7:0]        cr_clr,
    input logic [15:0]       cr_out
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sp_out == '0 && flags_out == '0 && ip_out == BOOT_IP));

    // R5
    unused_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_a_sel) > NGPR) |-> (rd_a_data == '0));

    // R6
    flags_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[3:0] == 4'h0);

    // R6
    flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |=> (flags_out[7:4] == $past(flags_in[7:4])));

    // R6
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |=> $stable(flags_out));

    // R7
    sp_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_adj_en && !sp_adj_pop && !(wr_en && int'(wr_sel) == NGPR))
        |=> (sp_out == $past(sp_out) - (DATA_W'(1) << $past(sp_adj_size))));

    // R7
    sp_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_adj_en && sp_adj_pop && !(wr_en && int'(wr_sel) == NGPR))
        |=> (sp_out == $past(sp_out) + (DATA_W'(1) << $past(sp_adj_size))));

    // R8
    ip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load_en |=> (ip_out == $past(ip_load_val)));

    // R9
    cr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_set[7] |=> cr_out[7]);

    // R9
    cr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_clr[6] && !cr_set[6]) |=> !cr_out[6]);

    // R9
    cr_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_out[5:0] == 6'h00);
endmodule

bind arch_regfile rf_checker #(
    .DATA_W  (DATA_W),
    .NGPR    (NGPR),
    .SEL_W   (SEL_W),
    .BOOT_IP (BOOT_IP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .rd_a_sel    (rd_a_sel),
    .rd_a_data   (rd_a_data),
    .sp_adj_en   (sp_adj_en),
    .sp_adj_pop  (sp_adj_pop),
    .sp_adj_size (sp_adj_size),
    .sp_out      (sp_out),
    .ip_load_en  (ip_load_en),
    .ip_load_val (ip_load_val),
    .ip_out      (ip_out),
    .flags_we    (flags_we),
    .flags_in    (flags_in),
    .flags_out   (flags_out),
    .cr_set      (cr_set),
    .cr_clr      (cr_clr),
    .cr_out      (cr_out)
);

// File: tb/test_arch_regfile.sv
// Self-checking bench: sweeps selectors, sizes, flags and control masks.
module test_arch_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;
    localparam logic [3:0] MAJ = 4'hA;
    localparam logic [3:0] MIN = 4'h5;
    localparam logic [63:0] BOOT = 64'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_a_sel = '0, rd_b_sel = '0;
    logic [1:0]  rd_a_size = '0, rd_b_size = '0;
    logic [63:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [1:0]  wr_size = '0;
    logic [63:0] wr_data = '0;
    logic        sp_adj_en = 1'b0, sp_adj_pop = 1'b0;
    logic [1:0]  sp_adj_size = '0;
    logic [63:0] sp_out;
    logic        ip_load_en = 1'b0, ip_step_en = 1'b0;
    logic [63:0] ip_load_val = '0;
    logic [3:0]  ip_step = '0;
    logic [63:0] ip_out;
    logic        flags_we = 1'b0;
    logic [7:0]  flags_in = '0, flags_out;
    logic [7:0]  cr_set = '0, cr_clr = '0;
    logic [15:0] cr_out;

    int tests = 0;
    int fails = 0;
    logic [63:0] mdl [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    arch_regfile #(.VER_MAJOR(MAJ), .VER_MINOR(MIN), .BOOT_IP(BOOT)) i_arch_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
        .sp_adj_en(sp_adj_en), .sp_adj_pop(sp_adj_pop), .sp_adj_size(sp_adj_size),
        .sp_out(sp_out),
        .ip_load_en(ip_load_en), .ip_load_val(ip_load_val),
        .ip_step_en(ip_step_en), .ip_step(ip_step), .ip_out(ip_out),
        .flags_we(flags_we), .flags_in(flags_in), .flags_out(flags_out),
        .cr_set(cr_set), .cr_clr(cr_clr), .cr_out(cr_out)
    );

    function automatic logic [63:0] lane(int sz);
        case (sz)
            0: return 64'h0000_0000_0000_00FF;
            1: return 64'h0000_0000_0000_FFFF;
            2: return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) mdl[i] = '0;
    endtask

    // Both ports, every selector and size; B uses mirrored selector/size (R10).
    task automatic read_sweep(string req);
        for (int rs = 0; rs < 8; rs++) begin
            for (int sz = 0; sz < 4; sz++) begin
                logic [63:0] ea, eb;
                rd_a_sel = 3'(rs);  rd_a_size = 2'(sz);
                rd_b_sel = 3'(7 - rs); rd_b_size = 2'(3 - sz);
                ea = (rs <= 4) ? (mdl[rs] & lane(sz)) : 64'd0;
                eb = (7 - rs <= 4) ? (mdl[7 - rs] & lane(3 - sz)) : 64'd0;
                #1;
                chk(req, rd_a_data, ea);
                chk("R10", rd_b_data, eb);
            end
        end
    endtask

    task automatic do_write(int sel, int sz, logic [63:0] d);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_size = 2'(sz); wr_data = d;
        tick();
        wr_en = 1'b0;
        if (sel <= 4) mdl[sel] = (mdl[sel] & ~lane(sz)) | (d & lane(sz));
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] e;
        logic [7:0]  crl;
        do_reset();
        // R1: reset state
        chk("R1", sp_out, 64'd0);
        chk("R1", ip_out, BOOT);
        chk("R1", {56'd0, flags_out}, 64'd0);
        chk("R1", {48'd0, cr_out}, {48'd0, MAJ, MIN, 8'h00});
        read_sweep("R1");

        // R2: word writes to each register
        for (int s = 0; s < 5; s++)
            do_write(s, 3, 64'hF0E1_D2C3_B4A5_9687 ^ (64'(s) * 64'h0101_0101_0101_0101));
        read_sweep("R2");

        // R3/R4/R5: every selector, size and a few patterns
        for (int k = 0; k < 3; k++)
            for (int s = 0; s < 8; s++)
                for (int sz = 0; sz < 4; sz++) begin
                    do_write(s, sz, 64'h9E37_79B9_7F4A_7C15 * 64'(k * 37 + s * 5 + sz + 1));
                    rd_a_sel = 3'(s); rd_a_size = 2'd3; #1;
                    chk(sz == 3 ? "R2" : "R3", rd_a_data, (s <= 4) ? mdl[s] : 64'd0);
                end
        read_sweep("R4");
        // R5: writes to unused selectors leave every register intact
        for (int s = 5; s < 8; s++) do_write(s, 3, 64'hDEAD_BEEF_DEAD_BEEF);
        read_sweep("R5");

        // R7: push/pop each size, and wrap
        do_write(4, 3, 64'h1000);
        for (int sz = 0; sz < 4; sz++) begin
            sp_adj_en = 1'b1; sp_adj_pop = 1'b0; sp_adj_size = 2'(sz);
            tick();
            chk("R7", sp_out, 64'h1000 - (64'd1 << sz));
            sp_adj_pop = 1'b1;
            tick();
            sp_adj_en = 1'b0;
            chk("R7", sp_out, 64'h1000);
        end
        do_write(4, 3, 64'd0);
        sp_adj_en = 1'b1; sp_adj_pop = 1'b0; sp_adj_size = 2'd3;
        tick();
        chk("R7", sp_out, 64'hFFFF_FFFF_FFFF_FFF8);
        // R7: explicit write wins over adjustment
        wr_en = 1'b1; wr_sel = 3'd4; wr_size = 2'd3; wr_data = 64'h55;
        tick();
        wr_en = 1'b0; sp_adj_en = 1'b0;
        chk("R7", sp_out, 64'h55);
        mdl[4] = 64'h55;

        // R8: load, step each length, load over step
        ip_load_en = 1'b1; ip_load_val = 64'h4000;
        tick();
        ip_load_en = 1'b0;
        chk("R8", ip_out, 64'h4000);
        e = 64'h4000;
        for (int l = 0; l < 16; l++) begin
            ip_step_en = 1'b1; ip_step = 4'(l);
            tick();
            e = e + 64'(l);
            chk("R8", ip_out, e);
        end
        ip_load_en = 1'b1; ip_load_val = 64'h1234;
        tick();
        ip_load_en = 1'b0; ip_step_en = 1'b0;
        chk("R8", ip_out, 64'h1234);

        // R6: every flags value, then hold
        for (int v = 0; v < 256; v++) begin
            flags_we = 1'b1; flags_in = 8'(v);
            tick();
            chk("R6", {56'd0, flags_out}, {56'd0, 8'(v) & 8'hF0});
        end
        flags_we = 1'b0; flags_in = 8'h0F;
        tick();
        chk("R6", {56'd0, flags_out}, 64'hF0);

        // R9: set/clear pairs over bits 7,6,5,0
        crl = 8'h00;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                logic [7:0] sm, cm;
                sm = {a[3], a[2], a[1], 4'b0, a[0]};
                cm = {b[3], b[2], b[1], 4'b0, b[0]};
                cr_set = sm; cr_clr = cm;
                tick();
                crl[7] = sm[7] ? 1'b1 : (cm[7] ? 1'b0 : crl[7]);
                crl[6] = sm[6] ? 1'b1 : (cm[6] ? 1'b0 : crl[6]);
                chk("R9", {48'd0, cr_out}, {48'd0, MAJ, MIN, crl});
            end
        cr_set = '0; cr_clr = '0;

        // R1: reset again after activity
        do_reset();
        chk("R1", sp_out, 64'd0);
        chk("R1", ip_out, BOOT);
        chk("R1", {56'd0, flags_out}, 64'd0);
        chk("R1", {48'd0, cr_out}, {48'd0, MAJ, MIN, 8'h00});
        read_sweep("R1");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule